// File: doc/BRIEF.md
# Debug Port Transaction Engine

This block sits on the host side of a debug link and turns single register requests into the scan operations a JTAG debug port expects. A request names either the debug port or an access port, an 8-bit register address, a direction and write data. The engine drives a separate bit shifter through a scan-request interface. It carries a 4-bit instruction code, a 2-bit register field, a direction bit, 32 data bits and a count of idle clocks to append. It waits for the shifter's completion pulse, which returns a 3-bit acknowledge and 32 captured data bits.

Access-port registers are banked. The engine remembers which bank it last programmed into the port's bank-select register and rewrites that register only when a request moves to a different bank. Reads on this link are posted, so every read is followed by a read of the read-buffer register, and the data of that second scan is the result. When the request asks for an end check, the engine polls the control/status register. It retries while the port answers WAIT, gives up after a cycle budget, rejects unknown acknowledges, and clears sticky error flags when it finds them. A one-cycle completion pulse then reports a 2-bit status, the read data and a power-lost flag.

Top module: `dpx_engine`

## Requirements
- R1: `req_ready` is high only while no request is in progress, and `scan_valid` is then low. Each accepted request ends with exactly one single-cycle `done` pulse.
- R2: An access-port request (`req_ap`=1) whose bank `req_addr[7:4]` differs from the cached bank first issues a scan with instruction 4'hA, register field 2 and a write. Its data holds the latched `ap_num` in bits [31:24], the new bank in bits [7:4] and zeros elsewhere. The cache then holds the new bank.
- R3: The bank cache resets invalid, so the first access-port request always writes the bank-select register. An access-port request whose bank equals the cached bank goes straight to its own scan with instruction 4'hB.
- R4: A debug-port request (`req_ap`=0) is issued as instruction 4'hA with register field `req_addr[3:2]`, and it leaves the bank cache unchanged.
- R5: A read is followed by a scan with instruction 4'hA, register field 3 and a read. The `rdata` reported with `done` is the data captured by that second scan, even when an end check follows. Write scans carry `req_wdata`, and read scans carry zero.
- R6: A scan with instruction 4'hB to address 8'h0C, or to any address with bits [7:4]=4'h1, carries `scan_idle` equal to the latched `idle_tck`. Every other scan carries 0.
- R7: With `req_chk`=1, the request's scans are followed by a pair of reads: instruction 4'hA field 1, then instruction 4'hA field 3. An acknowledge of 3'b010 on the second read, with bits 1 and 5 of its data clear, ends with status 2'b00.
- R8: An acknowledge of 3'b001 on that second read repeats the pair. Once `TIMEOUT_CYC` cycles have passed since acceptance, a further 3'b001 ends the request with status 2'b01.
- R9: Any other acknowledge on the check read ends the request at once with status 2'b10.
- R10: If the check data has bit 1 or bit 5 set, the engine writes field 1 with that data ORed with 32'h22, repeats the read pair, and ends with status 2'b11.
- R11: `pwr_lost` is 1 with `done` when an accepted check read had bits [31:28] other than 4'hF. It is 0 otherwise, including for requests without a check.
- R12: While `scan_valid` is high and `scan_done` has not arrived, the instruction, field, direction and data of the scan do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request taken this cycle if valid |
| req_ap | input | 1 | 1 = access-port register, 0 = debug-port register |
| req_addr | input | 8 | Register address; [7:4] bank, [3:2] register field |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_wdata | input | 32 | Write data |
| req_chk | input | 1 | Run the control/status end check after the access |
| ap_num | input | 8 | Access-port number placed in bank-select writes |
| idle_tck | input | IDLE_W | Idle clocks requested after data-register accesses |
| scan_valid | output | 1 | Scan request held until completion |
| scan_ir | output | 4 | Instruction: 4'hA debug-port access, 4'hB access-port access |
| scan_addr | output | 2 | Register field of the scan |
| scan_rnw | output | 1 | Scan direction, 1 = read |
| scan_wdata | output | 32 | Data shifted out |
| scan_idle | output | IDLE_W | Idle clocks to run after the scan |
| scan_done | input | 1 | Shifter completion pulse |
| scan_ack | input | 3 | Acknowledge captured by the scan |
| scan_rdata | input | 32 | Data captured by the scan |
| done | output | 1 | Request finished (one cycle) |
| rdata | output | 32 | Read result, valid with `done` |
| status | output | 2 | 00 ok, 01 timeout, 10 bad acknowledge, 11 sticky error |
| pwr_lost | output | 1 | Debug power bits not all set in the check read |

## Verification
The bench builds the engine with `TIMEOUT_CYC` = 60 instead of the default 4096 and keeps `IDLE_W` at 8. Its target model answers every scan after two cycles, so a read pair takes eight cycles. A short WAIT burst therefore finishes well inside the budget, while an endless WAIT reaches the timeout after about seven retries. With an 8-bit idle count, both a nonzero and a zero idle request fit into the scan stream that the bench compares.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int BANK_W = 4;
  localparam int IR_W   = 4;
  localparam int ACK_W  = 3;

  localparam logic [IR_W-1:0]  IR_DPORT = 4'hA;
  localparam logic [IR_W-1:0]  IR_APORT = 4'hB;

  localparam logic [1:0] FLD_CTRL = 2'd1;
  localparam logic [1:0] FLD_BSEL = 2'd2;
  localparam logic [1:0] FLD_RBUF = 2'd3;

  localparam logic [ACK_W-1:0] ACK_GOOD = 3'b010;
  localparam logic [ACK_W-1:0] ACK_BUSY = 3'b001;

  localparam logic [DATA_W-1:0] STICKY_MASK = 32'h0000_0022;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_TMO    = 2'd1,
    ST_BADACK = 2'd2,
    ST_STICKY = 2'd3
  } dpx_status_e;

  function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
    return a[7:4];
  endfunction

  function automatic logic wants_idle(input logic ap, input logic [ADDR_W-1:0] a);
    return ap && ((a == 8'h0C) || (a[7:4] == 4'h1));
  endfunction

  function automatic logic [DATA_W-1:0] select_word(input logic [7:0] apn,
                                                     input logic [BANK_W-1:0] b);
    return {apn, 16'h0000, b, 4'h0};
  endfunction

  function automatic logic sticky_seen(input logic [DATA_W-1:0] v);
    return (v & STICKY_MASK) != '0;
  endfunction

  function automatic logic power_ok(input logic [DATA_W-1:0] v);
    return v[31:28] == 4'hF;
  endfunction

endpackage

// File: rtl/dpx_bank_cache.sv
module dpx_bank_cache #(
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] probe_bank,
  input  logic          load,
  input  logic [BW-1:0] load_bank,
  output logic          hit
);
  logic          vld_q;
  logic [BW-1:0] bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      bank_q <= '0;
    end else if (load) begin
      vld_q  <= 1'b1;
      bank_q <= load_bank;
    end
  end

  assign hit = vld_q && (bank_q == probe_bank);
endmodule

// File: rtl/dpx_wait_timer.sv
module dpx_wait_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  assign expired = (cnt_q >= LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clear)      cnt_q <= '0;
    else if (run && !expired) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dpx_seq.sv
module dpx_seq
  import dpx_pkg::*;
#(
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_ap,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_rnw,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_chk,
  input  logic [7:0]        ap_num,
  input  logic [IDLE_W-1:0] idle_tck,
  input  logic              bank_hit,
  output logic              cache_load,
  output logic [BANK_W-1:0] cache_bank,
  output logic              tmr_clear,
  output logic              tmr_run,
  input  logic              tmr_expired,
  output logic              scan_valid,
  output logic [IR_W-1:0]   scan_ir,
  output logic [1:0]        scan_addr,
  output logic              scan_rnw,
  output logic [DATA_W-1:0] scan_wdata,
  output logic [IDLE_W-1:0] scan_idle,
  input  logic              scan_done,
  input  logic [ACK_W-1:0]  scan_ack,
  input  logic [DATA_W-1:0] scan_rdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        status,
  output logic              pwr_lost
);
  typedef enum logic [3:0] {
    S_IDLE, S_SEL, S_MAIN, S_RBUF, S_CKRD, S_CKBUF,
    S_CLRW, S_RERD, S_REBUF, S_FIN
  } seq_state_e;

  seq_state_e        st_q;
  logic              ap_q, rnw_q, chk_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, ctrl_q, rdata_q;
  logic [7:0]        apn_q;
  logic [IDLE_W-1:0] idle_q;
  dpx_status_e       status_q;
  logic              pwr_q;
  logic              accept;

  assign req_ready  = (st_q == S_IDLE);
  assign accept     = req_valid && req_ready;
  assign tmr_clear  = accept;
  assign tmr_run    = (st_q != S_IDLE);
  assign cache_load = (st_q == S_SEL) && scan_done;
  assign cache_bank = bank_of(addr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      ap_q     <= 1'b0;
      rnw_q    <= 1'b0;
      chk_q    <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      ctrl_q   <= '0;
      rdata_q  <= '0;
      apn_q    <= '0;
      idle_q   <= '0;
      status_q <= ST_OK;
      pwr_q    <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (accept) begin
          ap_q     <= req_ap;
          rnw_q    <= req_rnw;
          chk_q    <= req_chk;
          addr_q   <= req_addr;
          wdata_q  <= req_wdata;
          apn_q    <= ap_num;
          idle_q   <= idle_tck;
          rdata_q  <= '0;
          status_q <= ST_OK;
          pwr_q    <= 1'b0;
          st_q     <= (req_ap && !bank_hit) ? S_SEL : S_MAIN;
        end
        S_SEL: if (scan_done) st_q <= S_MAIN;
        S_MAIN: if (scan_done) begin
          if (rnw_q)      st_q <= S_RBUF;
          else if (chk_q) st_q <= S_CKRD;
          else            st_q <= S_FIN;
        end
        S_RBUF: if (scan_done) begin
          rdata_q <= scan_rdata;
          st_q    <= chk_q ? S_CKRD : S_FIN;
        end
        S_CKRD: if (scan_done) st_q <= S_CKBUF;
        S_CKBUF: if (scan_done) begin
          if (scan_ack == ACK_GOOD) begin
            ctrl_q <= scan_rdata;
            pwr_q  <= !power_ok(scan_rdata);
            st_q   <= sticky_seen(scan_rdata) ? S_CLRW : S_FIN;
          end else if (scan_ack == ACK_BUSY) begin
            if (tmr_expired) begin
              status_q <= ST_TMO;
              st_q     <= S_FIN;
            end else begin
              st_q     <= S_CKRD;
            end
          end else begin
            status_q <= ST_BADACK;
            st_q     <= S_FIN;
          end
        end
        S_CLRW:  if (scan_done) st_q <= S_RERD;
        S_RERD:  if (scan_done) st_q <= S_REBUF;
        S_REBUF: if (scan_done) begin
          status_q <= ST_STICKY;
          st_q     <= S_FIN;
        end
        S_FIN:   st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    scan_valid = 1'b1;
    scan_ir    = IR_DPORT;
    scan_addr  = FLD_RBUF;
    scan_rnw   = 1'b1;
    scan_wdata = '0;
    scan_idle  = '0;
    unique case (st_q)
      S_SEL: begin
        scan_addr  = FLD_BSEL;
        scan_rnw   = 1'b0;
        scan_wdata = select_word(apn_q, bank_of(addr_q));
      end
      S_MAIN: begin
        scan_ir    = ap_q ? IR_APORT : IR_DPORT;
        scan_addr  = addr_q[3:2];
        scan_rnw   = rnw_q;
        scan_wdata = rnw_q ? '0 : wdata_q;
        scan_idle  = wants_idle(ap_q, addr_q) ? idle_q : '0;
      end
      S_RBUF, S_CKBUF, S_REBUF: scan_addr = FLD_RBUF;
      S_CKRD, S_RERD:           scan_addr = FLD_CTRL;
      S_CLRW: begin
        scan_addr  = FLD_CTRL;
        scan_rnw   = 1'b0;
        scan_wdata = ctrl_q | STICKY_MASK;
      end
      default: scan_valid = 1'b0;
    endcase
  end

  assign done     = (st_q == S_FIN);
  assign rdata    = rdata_q;
  assign status   = status_q;
  assign pwr_lost = pwr_q;
endmodule

// File: rtl/dpx_engine.sv
module dpx_engine
  import dpx_pkg::*;
#(
  parameter int IDLE_W      = 8,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_ap,
  input  logic [7:0]        req_addr,
  input  logic              req_rnw,
  input  logic [31:0]       req_wdata,
  input  logic              req_chk,
  input  logic [7:0]        ap_num,
  input  logic [IDLE_W-1:0] idle_tck,
  output logic              scan_valid,
  output logic [3:0]        scan_ir,
  output logic [1:0]        scan_addr,
  output logic              scan_rnw,
  output logic [31:0]       scan_wdata,
  output logic [IDLE_W-1:0] scan_idle,
  input  logic              scan_done,
  input  logic [2:0]        scan_ack,
  input  logic [31:0]       scan_rdata,
  output logic              done,
  output logic [31:0]       rdata,
  output logic [1:0]        status,
  output logic              pwr_lost
);
  // named internal events, observed by the bound checker
  logic              bank_hit;
  logic              cache_load;
  logic [BANK_W-1:0] cache_bank;
  logic              tmr_clear;
  logic              tmr_run;
  logic              tmo_expired;
  logic              accept;

  assign accept = req_valid && req_ready;

  dpx_bank_cache #(.BW(BANK_W)) u_cache (
    .clk        (clk),
    .rst_n      (rst_n),
    .probe_bank (bank_of(req_addr)),
    .load       (cache_load),
    .load_bank  (cache_bank),
    .hit        (bank_hit)
  );

  dpx_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (tmr_clear),
    .run     (tmr_run),
    .expired (tmo_expired)
  );

  dpx_seq #(.IDLE_W(IDLE_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_ap      (req_ap),
    .req_addr    (req_addr),
    .req_rnw     (req_rnw),
    .req_wdata   (req_wdata),
    .req_chk     (req_chk),
    .ap_num      (ap_num),
    .idle_tck    (idle_tck),
    .bank_hit    (bank_hit),
    .cache_load  (cache_load),
    .cache_bank  (cache_bank),
    .tmr_clear   (tmr_clear),
    .tmr_run     (tmr_run),
    .tmr_expired (tmo_expired),
    .scan_valid  (scan_valid),
    .scan_ir     (scan_ir),
    .scan_addr   (scan_addr),
    .scan_rnw    (scan_rnw),
    .scan_wdata  (scan_wdata),
    .scan_idle   (scan_idle),
    .scan_done   (scan_done),
    .scan_ack    (scan_ack),
    .scan_rdata  (scan_rdata),
    .done        (done),
    .rdata       (rdata),
    .status      (status),
    .pwr_lost    (pwr_lost)
  );
endmodule

// File: rtl/dpx_engine_chk.sv
module dpx_engine_chk #(
  parameter int IDLE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              req_ready,
  input logic              req_ap,
  input logic [7:0]        req_addr,
  input logic              bank_hit,
  input logic              tmo_expired,
  input logic              scan_valid,
  input logic [3:0]        scan_ir,
  input logic [1:0]        scan_addr,
  input logic              scan_rnw,
  input logic [31:0]       scan_wdata,
  input logic [IDLE_W-1:0] scan_idle,
  input logic              scan_done,
  input logic              done,
  input logic [1:0]        status
);
  assert_idle_no_scan_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !scan_valid);

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_miss_selects_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_ap && !bank_hit) |=>
      (scan_valid && scan_ir == 4'hA && scan_addr == 2'd2 && !scan_rnw));

  assert_hit_skips_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_ap && bank_hit) |=> (scan_valid && scan_ir == 4'hB));

  assert_dport_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_ap) |=>
      (scan_valid && scan_ir == 4'hA && scan_addr == $past(req_addr[3:2])));

  assert_idle_only_ap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_valid && scan_ir != 4'hB) |-> (scan_idle == '0));

  assert_timeout_budget_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd1) |-> tmo_expired);

  assert_scan_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_valid && !scan_done) |=>
      (scan_valid && $stable(scan_ir) && $stable(scan_addr) &&
       $stable(scan_rnw) && $stable(scan_wdata)));
endmodule

bind dpx_engine dpx_engine_chk #(.IDLE_W(IDLE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .accept      (accept),
  .req_ready   (req_ready),
  .req_ap      (req_ap),
  .req_addr    (req_addr),
  .bank_hit    (bank_hit),
  .tmo_expired (tmo_expired),
  .scan_valid  (scan_valid),
  .scan_ir     (scan_ir),
  .scan_addr   (scan_addr),
  .scan_rnw    (scan_rnw),
  .scan_wdata  (scan_wdata),
  .scan_idle   (scan_idle),
  .scan_done   (scan_done),
  .done        (done),
  .status      (status)
);

// File: tb/dpx_engine_test.sv
module dpx_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 60;
  localparam int LAT        = 2;
  localparam logic [31:0] ID_WORD = 32'h1234_5671;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_ap = 1'b0;
  logic [7:0]  req_addr = '0;
  logic        req_rnw = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        req_chk = 1'b0;
  logic [7:0]  ap_num = 8'h03;
  logic [7:0]  idle_tck = 8'd5;
  logic        scan_valid;
  logic [3:0]  scan_ir;
  logic [1:0]  scan_addr;
  logic        scan_rnw;
  logic [31:0] scan_wdata;
  logic [7:0]  scan_idle;
  logic        scan_done = 1'b0;
  logic [2:0]  scan_ack = '0;
  logic [31:0] scan_rdata = '0;
  logic        done;
  logic [31:0] rdata;
  logic [1:0]  status;
  logic        pwr_lost;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpx_engine #(.IDLE_W(8), .TIMEOUT_CYC(TMO)) uut (.*);

  typedef struct {
    logic [3:0]  ir;
    logic [1:0]  fld;
    logic        rnw;
    logic [31:0] wd;
    logic [7:0]  idl;
    string       tag;
  } scan_item_t;

  typedef struct {
    logic        chk_data;
    logic [31:0] rd;
    logic [1:0]  st;
    logic        pw;
    string       tag;
  } res_item_t;

  scan_item_t exp_scan[$];
  res_item_t  exp_res[$];

  int n_vec = 0;
  int n_bad = 0;
  int n_scan = 0;
  int n_done = 0;
  bit loose = 1'b0;

  // target model state
  logic [31:0] ctrl_m = 32'hF000_0000;
  logic [31:0] sel_m = '0;
  logic [31:0] posted_m = '0;
  bit          prev_ctrl = 1'b0;
  int          wait_left = 0;
  logic [2:0]  bad_once = '0;

  // bench view of the bank cache
  bit          bv = 1'b0;
  logic [3:0]  bb = '0;

  function automatic void chk(input bit ok, input string tag, input string what,
                              input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endfunction

  function automatic void push_scan(input logic [3:0] ir, input logic [1:0] f,
                                    input logic rnw, input logic [31:0] wd,
                                    input logic [7:0] idl, input string tag);
    scan_item_t s;
    s.ir = ir; s.fld = f; s.rnw = rnw; s.wd = wd; s.idl = idl; s.tag = tag;
    exp_scan.push_back(s);
  endfunction

  // responder and scan monitor
  initial begin
    forever begin
      @(negedge clk);
      if (scan_valid) begin
        logic [3:0]  c_ir;
        logic [1:0]  c_f;
        logic        c_r;
        logic [31:0] c_w;
        logic [2:0]  a;
        logic [31:0] d;
        c_ir = scan_ir; c_f = scan_addr; c_r = scan_rnw; c_w = scan_wdata;
        n_scan++;
        if (!loose) begin
          if (exp_scan.size() == 0) begin
            chk(1'b0, "R1", "unexpected scan", {24'h0, c_ir, 2'b0, c_f}, 32'h0);
          end else begin
            scan_item_t e;
            e = exp_scan.pop_front();
            chk(c_ir == e.ir && c_f == e.fld && c_r == e.rnw, e.tag, "scan kind",
                {24'h0, c_ir, c_r, 1'b0, c_f}, {24'h0, e.ir, e.rnw, 1'b0, e.fld});
            chk(c_w == e.wd, e.tag, "scan data", c_w, e.wd);
            chk(scan_idle == e.idl, e.tag, "scan idle", {24'h0, scan_idle}, {24'h0, e.idl});
          end
        end
        a = 3'b010; d = '0;
        if (c_r && c_ir == 4'hA && c_f == 2'd3) begin
          d = posted_m;
          if (prev_ctrl && wait_left > 0) begin a = 3'b001; wait_left--; end
          else if (prev_ctrl && bad_once != 3'b000) begin a = bad_once; bad_once = '0; end
        end
        if (c_r && c_ir == 4'hB)
          posted_m = {sel_m[31:24], 8'h5A, 8'h00, sel_m[7:4], c_f, 2'b00};
        if (c_r && c_ir == 4'hA && c_f == 2'd1) posted_m = ctrl_m;
        if (c_r && c_ir == 4'hA && c_f == 2'd0) posted_m = ID_WORD;
        if (!c_r && c_ir == 4'hA && c_f == 2'd2) sel_m = c_w;
        if (!c_r && c_ir == 4'hA && c_f == 2'd1) ctrl_m = ctrl_m & ~(c_w & 32'h22);
        if (c_r) prev_ctrl = (c_ir == 4'hA && c_f == 2'd1);
        repeat (LAT) @(negedge clk);
        scan_ack = a; scan_rdata = d; scan_done = 1'b1;
        @(negedge clk);
        scan_done = 1'b0;
      end
    end
  end

  // result monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        n_done++;
        if (exp_res.size() == 0) begin
          chk(1'b0, "R1", "unexpected done", 32'h1, 32'h0);
        end else begin
          res_item_t r;
          r = exp_res.pop_front();
          if (r.chk_data) chk(rdata == r.rd, r.tag, "rdata", rdata, r.rd);
          chk(status == r.st, r.tag, "status", {30'h0, status}, {30'h0, r.st});
          chk(pwr_lost == r.pw, r.tag, "pwr_lost", {31'h0, pwr_lost}, {31'h0, r.pw});
        end
      end
    end
  end

  // driver: computes the expected scan stream and result, then offers the request
  task automatic run_req(input bit ap, input logic [7:0] addr, input bit rnw,
                         input logic [31:0] wd, input bit ck, input int waits,
                         input logic [2:0] bad, input string tag);
    res_item_t r;
    logic [3:0] bank;
    int target;
    bank = addr[7:4];
    r.tag = tag; r.chk_data = rnw; r.rd = '0; r.st = 2'd0; r.pw = 1'b0;
    if (ap && !(bv && bb == bank)) begin
      push_scan(4'hA, 2'd2, 1'b0, {ap_num, 16'h0, bank, 4'h0}, 8'd0, tag);
      bv = 1'b1; bb = bank;
    end
    push_scan(ap ? 4'hB : 4'hA, addr[3:2], rnw, rnw ? 32'h0 : wd,
              (ap && (addr == 8'h0C || bank == 4'h1)) ? idle_tck : 8'd0, tag);
    if (rnw) begin
      push_scan(4'hA, 2'd3, 1'b1, 32'h0, 8'd0, tag);
      if (ap) r.rd = {ap_num, 8'h5A, 8'h00, bank, addr[3:2], 2'b00};
      else if (addr[3:2] == 2'd1) r.rd = ctrl_m;
      else r.rd = ID_WORD;
    end
    if (ck) begin
      if (bad != 3'b000) begin
        push_scan(4'hA, 2'd1, 1'b1, 32'h0, 8'd0, tag);
        push_scan(4'hA, 2'd3, 1'b1, 32'h0, 8'd0, tag);
        r.st = 2'd2;
      end else if (loose) begin
        r.st = 2'd1;
      end else begin
        for (int i = 0; i <= waits; i++) begin
          push_scan(4'hA, 2'd1, 1'b1, 32'h0, 8'd0, tag);
          push_scan(4'hA, 2'd3, 1'b1, 32'h0, 8'd0, tag);
        end
        r.pw = (ctrl_m[31:28] != 4'hF);
        if ((ctrl_m & 32'h22) != 0) begin
          push_scan(4'hA, 2'd1, 1'b0, ctrl_m | 32'h22, 8'd0, tag);
          push_scan(4'hA, 2'd1, 1'b1, 32'h0, 8'd0, tag);
          push_scan(4'hA, 2'd3, 1'b1, 32'h0, 8'd0, tag);
          r.st = 2'd3;
        end
      end
    end
    exp_res.push_back(r);
    wait_left = waits; bad_once = bad;
    target = n_done + 1;
    @(negedge clk);
    req_valid = 1'b1; req_ap = ap; req_addr = addr; req_rnw = rnw;
    req_wdata = wd; req_chk = ck;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (n_done < target) @(negedge clk);
    @(negedge clk);
    chk(exp_scan.size() == 0 || loose, tag, "scans left over", exp_scan.size(), 0);
    exp_scan.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1", "ready after reset", {31'h0, req_ready}, 32'h1);
    chk(scan_valid == 1'b0, "R1", "scan idle after reset", {31'h0, scan_valid}, 32'h0);
    chk(done == 1'b0, "R1", "done after reset", {31'h0, done}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 first access selects; R2 select word contents
    run_req(1'b1, 8'h04, 1'b0, 32'hCAFE_0001, 1'b0, 0, 3'b0, "R3");
    // R5 and R6: read of the data register in the same bank, idle added, no select
    run_req(1'b1, 8'h0C, 1'b1, 32'h0, 1'b0, 0, 3'b0, "R5");
    // R2 and R6: banked data register, new bank
    run_req(1'b1, 8'h14, 1'b1, 32'h0, 1'b0, 0, 3'b0, "R2");
    // R6: bank F register, no idle
    run_req(1'b1, 8'hF8, 1'b0, 32'h0000_ABCD, 1'b0, 0, 3'b0, "R6");
    // R4: debug-port read of control/status and write to field 0
    run_req(1'b0, 8'h04, 1'b1, 32'h0, 1'b0, 0, 3'b0, "R4");
    run_req(1'b0, 8'h00, 1'b0, 32'h0000_001E, 1'b0, 0, 3'b0, "R4");
    // R4: cache untouched, same bank F hits
    run_req(1'b1, 8'hF4, 1'b1, 32'h0, 1'b0, 0, 3'b0, "R4");
    // R6 with zero idle count
    idle_tck = 8'd0;
    run_req(1'b1, 8'h0C, 1'b0, 32'h1111_2222, 1'b0, 0, 3'b0, "R6");
    idle_tck = 8'd5;
    // R7: clean end check, read data kept (R5)
    run_req(1'b1, 8'h0C, 1'b1, 32'h0, 1'b1, 0, 3'b0, "R7");
    // R8: two WAITs then success
    run_req(1'b0, 8'h00, 1'b0, 32'h0, 1'b1, 2, 3'b0, "R8");
    // R8: endless WAIT gives timeout
    loose = 1'b1;
    s0 = n_scan;
    run_req(1'b0, 8'h00, 1'b0, 32'h0, 1'b1, 1000, 3'b0, "R8");
    loose = 1'b0; wait_left = 0;
    chk(n_scan - s0 >= 5, "R8", "retry scans", n_scan - s0, 5);
    // R9: invalid acknowledge
    run_req(1'b0, 8'h00, 1'b0, 32'h0, 1'b1, 0, 3'b111, "R9");
    run_req(1'b0, 8'h00, 1'b0, 32'h0, 1'b1, 0, 3'b100, "R9");
    // R10: sticky flags cleared
    ctrl_m = 32'hF000_0022;
    run_req(1'b0, 8'h00, 1'b0, 32'h0, 1'b1, 0, 3'b0, "R10");
    chk(ctrl_m == 32'hF000_0000, "R10", "flags cleared", ctrl_m, 32'hF000_0000);
    // R11: power lost, no sticky
    ctrl_m = 32'h5000_0000;
    run_req(1'b0, 8'h00, 1'b0, 32'h0, 1'b1, 0, 3'b0, "R11");
    // R11 with R10: power lost and sticky overrun
    ctrl_m = 32'h0000_0002;
    run_req(1'b1, 8'h10, 1'b1, 32'h0, 1'b1, 0, 3'b0, "R11");
    // R11: no check means no power flag
    run_req(1'b1, 8'h10, 1'b0, 32'h0, 1'b0, 0, 3'b0, "R11");
    // R12 covered by the scan monitor capturing fields at the first cycle of each scan

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule